// File: doc/BRIEF.md
# Configurable Pin Bank Controller

This block controls a bank of sixteen general-purpose chip pins from a small synchronous register bus. Software writes per-pin configuration: a two-bit operating mode, a drive style (push-pull or open-drain), a two-bit pull selection, a two-bit drive-strength code, and the level to drive. The block turns this configuration into three per-pin pad controls: output value, output enable and pull-up/pull-down enables. When a pin is handed to an on-chip peripheral, the block takes the pad value and enable from that peripheral instead.

Pad inputs pass through a two-flop synchronizer and then a sampling register. Software reads that register to learn the pin levels. Pins in analog mode read back as 0 and have no drive and no pull. The drive-strength codes are only stored and exported to the pad ring. The read path is combinational: read data reflects the address in the same cycle. A write takes effect at the next rising clock edge.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After synchronous active-low reset, the mode, drive-style, speed, pull and output-level registers all read 0. Every pin is an input: `pad_oe`, `pad_pu`, `pad_pd` and `pin_speed` are all 0.
- R2: Register offsets are 0x00 mode (2 bits per pin, pin n at bits 2n+1:2n), 0x04 drive style (bit n), 0x08 speed (2 bits per pin), 0x0C pull (2 bits per pin), 0x10 sampled input (bit n), 0x14 output level (bit n). Stored bits read back as written; unused upper bits read 0; any other offset reads 0.
- R3: Mode 00 (input) and mode 11 (analog) give `pad_oe`=0 and `pad_out`=0 for that pin.
- R4: Mode 01 with drive-style bit 0 gives `pad_oe`=1 and `pad_out` equal to the output-level bit.
- R5: With drive-style bit 1 (open-drain) in mode 01 or 10, the pin is enabled only when the selected value is 0, and `pad_out` is always 0.
- R6: Mode 10 takes the pad value from `alt_out` and the enable from `alt_oe`; the output-level register has no effect. In push-pull style `pad_oe`=`alt_oe` and `pad_out`=`alt_out & alt_oe`.
- R7: Pull code 01 sets `pad_pu`, code 10 sets `pad_pd`, and codes 00 and 11 set neither. In analog mode both are 0 whatever the code.
- R8: A level change on `pad_in` applied between clock edges appears in the sampled-input register after the third following rising edge, and not after the second.
- R9: A pin in analog mode reads 0 in the sampled-input register whatever its pad level.
- R10: Writes to the sampled-input offset or to an unmapped offset change no register.
- R11: `pin_speed` carries the speed register value, with pin n at bits 2n+1:2n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 16 | Raw pad levels |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| alt_out | input | 16 | Peripheral pad value per pin |
| alt_oe | input | 16 | Peripheral pad enable per pin |
| pin_speed | output | 32 | Per-pin drive-strength codes |

## Verification
The bench targets open-drain behaviour in both output and peripheral modes. A design that drives a 1 there, or ignores the peripheral's enable, shows the wrong `pad_oe` or `pad_out` pattern. It checks input-register latency at the exact edge, so a missing or extra synchronizer stage is caught. It also checks that analog pins read 0 and have no pull, which catches a missing mask. Finally, it writes to the read-only and unmapped offsets and reads every register back, which catches a decoder that aliases those writes onto the configuration registers.

// File: rtl/pin_bank_pkg.sv
// Package: shared mode encoding and register offsets for the pin bank.
// Assumes byte offsets fit in 8 bits.
package pin_bank_pkg;

    typedef enum logic [1:0] {
        PM_IN  = 2'b00,
        PM_OUT = 2'b01,
        PM_ALT = 2'b10,
        PM_ANA = 2'b11
    } pin_mode_e;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_STYLE = 8'h04;
    localparam logic [7:0] OFS_SPEED = 8'h08;
    localparam logic [7:0] OFS_PULL  = 8'h0C;
    localparam logic [7:0] OFS_SAMP  = 8'h10;
    localparam logic [7:0] OFS_LEVEL = 8'h14;

    localparam logic [1:0] PULL_UP   = 2'b01;
    localparam logic [1:0] PULL_DOWN = 2'b10;

endpackage

// File: rtl/pin_bank_regs.sv
// Module: pin_bank_regs
// Holds the configuration registers and decodes bus reads and writes.
// Assumes DW >= 2*NPINS and AW <= 8. Reads are combinational.
// Writes to read-only or unmapped offsets are dropped.
module pin_bank_regs
    import pin_bank_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_we,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NPINS-1:0]   samp_q,
    output logic [2*NPINS-1:0] mode_q,
    output logic [NPINS-1:0]   style_q,
    output logic [2*NPINS-1:0] speed_q,
    output logic [2*NPINS-1:0] pull_q,
    output logic [NPINS-1:0]   level_q
);
    localparam int MW = 2 * NPINS;

    logic [7:0] ofs;
    assign ofs = 8'(bus_addr);

    // Register update: reset to input/no-pull/zero, otherwise write on decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            style_q <= '0;
            speed_q <= '0;
            pull_q  <= '0;
            level_q <= '0;
        end else if (bus_we) begin
            case (ofs)
                OFS_MODE:  mode_q  <= bus_wdata[MW-1:0];
                OFS_STYLE: style_q <= bus_wdata[NPINS-1:0];
                OFS_SPEED: speed_q <= bus_wdata[MW-1:0];
                OFS_PULL:  pull_q  <= bus_wdata[MW-1:0];
                OFS_LEVEL: level_q <= bus_wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer: zero-extend the addressed register, 0 when unmapped.
    always_comb begin
        case (ofs)
            OFS_MODE:  bus_rdata = DW'(mode_q);
            OFS_STYLE: bus_rdata = DW'(style_q);
            OFS_SPEED: bus_rdata = DW'(speed_q);
            OFS_PULL:  bus_rdata = DW'(pull_q);
            OFS_SAMP:  bus_rdata = DW'(samp_q);
            OFS_LEVEL: bus_rdata = DW'(level_q);
            default:   bus_rdata = '0;
        endcase
    end

    // R1: the cycle after reset every configuration register is cleared.
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mode_q == '0 && style_q == '0 && speed_q == '0 &&
                           pull_q == '0 && level_q == '0))
        else $error("R1 reset state");

    // R10: a write to the read-only offset leaves every register unchanged.
    assert_samp_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ofs == OFS_SAMP) |=> ($stable(mode_q) && $stable(style_q) &&
            $stable(speed_q) && $stable(pull_q) && $stable(level_q)))
        else $error("R10 read-only write");

endmodule

// File: rtl/pin_bank_sync.sv
// Module: pin_bank_sync
// A STAGES-deep flop chain that synchronizes W asynchronous pad levels.
// Assumes STAGES >= 1. Reset clears every stage.
module pin_bank_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage: capture the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages: shift toward the output.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pin_bank_pad.sv
// Module: pin_bank_pad
// Turns one pin's configuration into its pad controls.
// Combinational; clk and rst_n serve only the assertions.
// The pad value is held at 0 whenever the enable is low.
module pin_bank_pad
    import pin_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       style_od,
    input  logic [1:0] pull,
    input  logic       level,
    input  logic       alt_val,
    input  logic       alt_en,
    output logic       out,
    output logic       oe,
    output logic       pu,
    output logic       pd
);
    logic sel_val;
    logic sel_en;

    // Source selection: output register or peripheral, by mode.
    always_comb begin
        case (pin_mode_e'(mode))
            PM_OUT:  begin sel_val = level;   sel_en = 1'b1;   end
            PM_ALT:  begin sel_val = alt_val; sel_en = alt_en; end
            default: begin sel_val = 1'b0;    sel_en = 1'b0;   end
        endcase
    end

    // Drive style: open-drain enables only to pull low; push-pull drives the value.
    always_comb begin
        if (style_od) begin
            oe  = sel_en & ~sel_val;
            out = 1'b0;
        end else begin
            oe  = sel_en;
            out = sel_en & sel_val;
        end
    end

    // Pull decode: disabled for analog pins.
    always_comb begin
        pu = (pin_mode_e'(mode) != PM_ANA) && (pull == PULL_UP);
        pd = (pin_mode_e'(mode) != PM_ANA) && (pull == PULL_DOWN);
    end

    // R5: an open-drain pin never drives a high level.
    assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (style_od && oe) |-> !out)
        else $error("R5 open-drain drove high");

    // R3: input and analog pins never enable the driver.
    assert_idle_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |-> (!oe && !out))
        else $error("R3 idle pin driven");

    // R7: pull-up and pull-down are never on together.
    assert_pull_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu && pd))
        else $error("R7 both pulls");

    // R6: a push-pull pin in peripheral mode follows the peripheral.
    assert_alt_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !style_od) |-> (oe == alt_en && out == (alt_en & alt_val)))
        else $error("R6 peripheral routing");

endmodule

// File: rtl/pin_bank_ctrl.sv
// Module: pin_bank_ctrl (top)
// Register-controlled pin bank. Pad inputs pass through a synchronizer into
// a sampled-input register that masks analog pins. One pad slice per pin.
// Assumes DW >= 2*NPINS.
module pin_bank_ctrl
    import pin_bank_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int AW          = 8,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_we,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_pu,
    output logic [NPINS-1:0]   pad_pd,
    input  logic [NPINS-1:0]   alt_out,
    input  logic [NPINS-1:0]   alt_oe,
    output logic [2*NPINS-1:0] pin_speed
);
    localparam int MW = 2 * NPINS;

    logic [MW-1:0]    mode_q;
    logic [NPINS-1:0] style_q;
    logic [MW-1:0]    speed_q;
    logic [MW-1:0]    pull_q;
    logic [NPINS-1:0] level_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] samp_q;
    logic [NPINS-1:0] ana_mask;

    pin_bank_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .samp_q    (samp_q),
        .mode_q    (mode_q),
        .style_q   (style_q),
        .speed_q   (speed_q),
        .pull_q    (pull_q),
        .level_q   (level_q)
    );

    pin_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign ana_mask[p] = (mode_q[2*p +: 2] == 2'b11);

        pin_bank_pad u_pad (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode_q[2*p +: 2]),
            .style_od (style_q[p]),
            .pull     (pull_q[2*p +: 2]),
            .level    (level_q[p]),
            .alt_val  (alt_out[p]),
            .alt_en   (alt_oe[p]),
            .out      (pad_out[p]),
            .oe       (pad_oe[p]),
            .pu       (pad_pu[p]),
            .pd       (pad_pd[p])
        );
    end

    // Sampled-input register: capture synchronized levels, analog pins forced to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= sync_q & ~ana_mask;
    end

    assign pin_speed = speed_q;

    // R9: a pin that was analog at the last edge reads 0.
    assert_analog_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ana_mask) & samp_q) == '0))
        else $error("R9 analog pin sampled nonzero");

endmodule

// File: tb/sim_pin_bank_ctrl.sv
`timescale 1ns/1ps
module sim_pin_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pu, pad_pd;
    logic [15:0] alt_out = '0;
    logic [15:0] alt_oe = '0;
    logic [31:0] pin_speed;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pin_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .alt_out(alt_out), .alt_oe(alt_oe), .pin_speed(pin_speed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(8'(i*4), v);
            check("R1 register after reset", v, 32'h0);
        end
        check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
        check("R1 pad_pu after reset", 32'(pad_pu), 32'h0);
        check("R1 pad_pd after reset", 32'(pad_pd), 32'h0);
        check("R1 pin_speed after reset", pin_speed, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v);
        check("R2 style readback width", v, 32'h0000_FFFF);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'hC3A5_1E72); rd(8'h08, v);
        check("R2 speed readback", v, 32'hC3A5_1E72);
        check("R11 pin_speed port", pin_speed, 32'hC3A5_1E72);
        wr(8'h14, 32'hFFFF_1357); rd(8'h14, v);
        check("R2 level readback width", v, 32'h0000_1357);
        rd(8'h18, v);
        check("R2 unmapped read", v, 32'h0);
        wr(8'h00, 32'h1234_5678); rd(8'h00, v);
        check("R2 mode readback", v, 32'h1234_5678);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_pushpull();
        wr(8'h00, 32'h5555_5555);
        wr(8'h14, 32'h0000_A5C3);
        check("R4 push-pull oe", 32'(pad_oe), 32'h0000_FFFF);
        check("R4 push-pull out", 32'(pad_out), 32'h0000_A5C3);
    endtask

    task automatic t_opendrain();
        wr(8'h04, 32'h0000_FFFF);
        check("R5 open-drain oe", 32'(pad_oe), 32'h0000_5A3C);
        check("R5 open-drain out", 32'(pad_out), 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_alt();
        @(negedge clk);
        alt_out = 16'h1234; alt_oe = 16'hFF00;
        wr(8'h00, 32'hAAAA_AAAA);
        check("R6 peripheral oe", 32'(pad_oe), 32'h0000_FF00);
        check("R6 peripheral out", 32'(pad_out), 32'h0000_1200);
        wr(8'h14, 32'h0000_FFFF);
        check("R6 level register ignored", 32'(pad_out), 32'h0000_1200);
        wr(8'h04, 32'h0000_FFFF);
        check("R5 R6 open-drain peripheral oe", 32'(pad_oe), 32'h0000_ED00);
        check("R5 R6 open-drain peripheral out", 32'(pad_out), 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_idle();
        wr(8'h14, 32'h0000_FFFF);
        wr(8'h00, 32'h0);
        check("R3 input mode oe", 32'(pad_oe), 32'h0);
        check("R3 input mode out", 32'(pad_out), 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        check("R3 analog mode oe", 32'(pad_oe), 32'h0);
        check("R3 analog mode out", 32'(pad_out), 32'h0);
    endtask

    task automatic t_pull();
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h3939_3939);
        check("R7 pull-up pins", 32'(pad_pu), 32'h0000_1111);
        check("R7 pull-down pins", 32'(pad_pd), 32'h0000_2222);
        wr(8'h00, 32'hFFFF_FFFF);
        check("R7 analog pull-up off", 32'(pad_pu), 32'h0);
        check("R7 analog pull-down off", 32'(pad_pd), 32'h0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_input();
        logic [31:0] v;
        wr(8'h00, 32'h0);
        repeat (4) @(negedge clk);
        pad_in = 16'hBEEF;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(8'h10, v);
        check("R8 not visible after two edges", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(8'h10, v);
        check("R8 visible after three edges", v, 32'h0000_BEEF);
    endtask

    task automatic t_analog_in();
        logic [31:0] v;
        wr(8'h00, 32'h0000_FFFF);
        repeat (4) @(negedge clk);
        rd(8'h10, v);
        check("R9 analog pins read zero", v, 32'h0000_BE00);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(8'h0C, 32'h0000_0000);
        wr(8'h04, 32'h0000_00F0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R10 mode kept", v, 32'h0000_FFFF);
        rd(8'h04, v); check("R10 style kept", v, 32'h0000_00F0);
        rd(8'h08, v); check("R10 speed kept", v, 32'hC3A5_1E72);
        rd(8'h0C, v); check("R10 pull kept", v, 32'h0);
        rd(8'h14, v); check("R10 level kept", v, 32'h0000_FFFF);
        rd(8'h10, v); check("R10 sampled input kept", v, 32'h0000_BE00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_pushpull();
        t_opendrain();
        t_alt();
        t_idle();
        t_pull();
        t_input();
        t_analog_in();
        t_readonly();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule